// File: doc/BRIEF.md
# Synchronous Burst SRAM Data Path

This block models the storage and data movement of a synchronous burst SRAM: a small word array split into four byte lanes, a two-bit burst address counter that steps through a four-word group in linear or interleaved order, and write decoding in which an all-lanes write overrides the per-lane write controls. All commands are taken at the rising clock edge.

Read data can be presented in one of two ways. In flow-through mode the array output goes straight to the data port, so the first word of a burst shows one edge after its command. In pipelined mode an extra output register adds one edge. A deselect takes the output drive away one pipeline stage sooner than a read would show data. The output enable and the sleep input act on the drive flag without waiting for a clock. Sleep also blocks every access and flushes the read pipeline, and the stored data is kept.

The tri-state bus is modelled as a data word plus a drive flag. The data word reads zero whenever the flag is low.

Top module: `sbsram_path`

## Requirements
- R1: After reset, `rdrive` is 0 and `rdata` is 0, and no access is in progress.
- R2: With `pipe_mode`=0 (flow-through), a read captured at edge k drives the addressed word on `rdata`, with `rdrive`=1, right after edge k.
- R3: With `pipe_mode`=1 (pipelined), a read captured at edge k drives its word only after edge k+1. Right after edge k the drive shows nothing for that read.
- R4: A cycle with `start_n`=0 and `ce_n`=0 begins a burst at `addr`. Each later cycle with `start_n`=1 continues the burst. With `burst_ilv`=0 and `adv_n`=0, the two low address bits become (base+n) mod 4 and the upper bits stay those of the base. With `adv_n`=1 the address is repeated.
- R5: With `burst_ilv`=1, beat n of a burst uses low address bits (base XOR n).
- R6: When `gw_n`=0, an access writes all four byte lanes from `wdata`, whatever `bw_n` and `be_n` are.
- R7: When `gw_n`=1 and `bw_n`=0, only the lanes whose `be_n` bit is 0 are written (bit i is bits 8i+7..8i). With all `be_n` bits at 1, nothing is written. When `gw_n`=1 and `bw_n`=1, the access is a read.
- R8: A write cycle never sets `rdrive`. A read right after a write to the same address returns the newly written bytes.
- R9: With `pipe_mode`=1, a deselect (`start_n`=0, `ce_n`=1) captured at edge k ends the burst. The word of a read captured at edge k-1 is still driven after edge k, and `rdrive` is 0 after edge k+1.
- R10: `oe_n`=1 forces `rdrive` to 0 and `rdata` to 0 at once, without a clock edge. Driving `oe_n` low again restores the pending word.
- R11: `sleep`=1 drops `rdrive` at once and blocks all reads and writes, and the stored words are kept. It flushes the read pipeline and ends the burst, so continuation cycles after `sleep` falls do nothing until a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined read output, 0 = flow-through |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| start_n | input | 1 | Address strobe, active low; loads a new address |
| ce_n | input | 1 | Chip enable, active low, sampled with `start_n` |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | 6 | Word address |
| gw_n | input | 1 | All-lanes write, active low |
| bw_n | input | 1 | Per-lane write enable, active low |
| be_n | input | 4 | Per-lane select, active low |
| wdata | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| rdata | output | 32 | Read data, zero when not driven |
| rdrive | output | 1 | Data bus drive flag |

## Verification
The assertions assume that `pipe_mode` and `burst_ilv` change only while no read is in flight. They also assume that `sleep` and `oe_n` settle away from the rising edge. The bench changes the mode inputs only after two deselect cycles, and it moves `oe_n` and `sleep` only in the low half of the clock. Because continuation cycles keep accessing memory while a burst is open, the bench closes every burst with an explicit deselect before it starts the next test.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} burst_order_e;

  function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input burst_order_e ord);
    return (ord == ORD_INTERLEAVE) ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 step,
  input  logic [ADDR_W-1:0]    addr_in,
  input  sbs_pkg::burst_order_e order,
  output logic [ADDR_W-1:0]    addr_out
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;

  always_comb begin
    if (load)      cnt_nx = 2'd0;
    else if (step) cnt_nx = cnt_q + 2'd1;
    else           cnt_nx = cnt_q;
    if (load) addr_out = addr_in;
    else      addr_out = {base_q[ADDR_W-1:2], sbs_pkg::beat_offset(base_q[1:0], cnt_nx, order)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (load) base_q <= addr_in;
      cnt_q <= cnt_nx;
    end
  end

  // R4: a continuation never leaves the four-word group of its base
  assert_group_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && $past(load)) |-> addr_out[ADDR_W-1:2] == $past(addr_in[ADDR_W-1:2]));
endmodule

// File: rtl/sbs_wr_decode.sv
module sbs_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             en,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] be_n,
  output logic             is_write,
  output logic [LANES-1:0] lane_we
);
  assign is_write = !gw_n || !bw_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = en && (!gw_n || (!bw_n && !be_n[i]));
  end
endmodule

// File: rtl/sbs_byte_ram.sv
module sbs_byte_ram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
      if (rd_en) rdata[i*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/sbsram_path.sv
module sbsram_path #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pipe_mode,
  input  logic                    burst_ilv,
  input  logic                    start_n,
  input  logic                    ce_n,
  input  logic                    adv_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gw_n,
  input  logic                    bw_n,
  input  logic [LANES-1:0]        be_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdrive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              session_q;
  logic              sel_new, desel, cont, access;
  logic              is_write, rd_go, wr_go;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] ram_q, pp_data;
  logic              ft_v, pp_v, present;
  logic [DATA_W-1:0] data_sel;

  assign sel_new = !start_n && !ce_n && !sleep;
  assign desel   = !start_n &&  ce_n && !sleep;
  assign cont    =  start_n && session_q && !sleep;
  assign access  = sel_new || cont;
  assign rd_go   = access && !is_write;
  assign wr_go   = access && is_write;

  always_ff @(posedge clk) begin
    if (rst || sleep)  session_q <= 1'b0;
    else if (!start_n) session_q <= !ce_n;
  end

  sbs_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(sel_new), .step(cont && !adv_n),
    .addr_in(addr), .order(sbs_pkg::burst_order_e'(burst_ilv)), .addr_out(cur_addr)
  );

  sbs_wr_decode #(.LANES(LANES)) u_dec (
    .en(access), .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n),
    .is_write(is_write), .lane_we(lane_we)
  );

  sbs_byte_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk(clk), .we(lane_we), .rd_en(rd_go), .addr(cur_addr), .wdata(wdata), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      ft_v <= 1'b0;
      pp_v <= 1'b0;
    end else begin
      ft_v <= rd_go;
      pp_v <= ft_v;
    end
    pp_data <= ram_q;
  end

  assign present  = pipe_mode ? pp_v : ft_v;
  assign data_sel = pipe_mode ? pp_data : ram_q;
  assign rdrive   = present && !oe_n && !sleep;
  assign rdata    = rdrive ? data_sel : '0;

  // R8: a write edge leaves nothing to drive in flow-through mode
  assert_write_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_go) && !pipe_mode) |-> !rdrive);
  // R6: an all-lanes write enables every lane
  assert_global_all_R6: assert property (@(posedge clk) disable iff (rst)
    (access && !gw_n) |-> &lane_we);
  // R3: the output register only holds data that passed the array stage
  assert_pipe_order_R3: assert property (@(posedge clk) disable iff (rst)
    pp_v |-> $past(ft_v));
  // R9: a deselect edge leaves the array stage empty
  assert_scd_R9: assert property (@(posedge clk) disable iff (rst)
    $past(desel) |-> !ft_v);
  // R11: sleep empties both read stages
  assert_sleep_flush_R11: assert property (@(posedge clk) disable iff (rst)
    $past(sleep) |-> (!ft_v && !pp_v));
endmodule

// File: tb/test_sbsram_path.sv
module test_sbsram_path;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pipe_mode = 1'b0, burst_ilv = 1'b0;
  logic        start_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1;
  logic [5:0]  addr = '0;
  logic        gw_n = 1'b1, bw_n = 1'b1;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] wdata = '0;
  logic        oe_n = 1'b0, sleep = 1'b0;
  logic [31:0] rdata;
  logic        rdrive;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [64];

  always #10 clk = ~clk;

  sbsram_path i_sbsram_path (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .start_n(start_n), .ce_n(ce_n), .adv_n(adv_n), .addr(addr),
    .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n), .wdata(wdata),
    .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rdrive(rdrive)
  );

  function automatic logic [31:0] pat(input int a, input int salt);
    return (32'h9E3779B9 * (a + 1)) ^ (32'h01010101 * salt);
  endfunction

  function automatic logic [5:0] baddr(input logic [5:0] b, input int n, input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ 2'(n)) : (b[1:0] + 2'(n));
    return {b[5:2], lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic s, input logic c, input logic adv, input logic g,
                     input logic b, input logic [3:0] e, input logic [5:0] a, input logic [31:0] d);
    start_n = s; ce_n = c; adv_n = adv; gw_n = g; bw_n = b; be_n = e; addr = a; wdata = d;
  endtask

  task automatic deselect2();
    cmd(0, 1, 1, 1, 1, 4'hF, 0, 0); tick();
    cmd(1, 1, 1, 1, 1, 4'hF, 0, 0); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 drive", {31'd0, rdrive}, 32'd0);
    chk("R1 data", rdata, 32'd0);

    // Fill with linear write bursts; all-lanes write ignores bw_n/be_n (R6, R4)
    for (int g = 0; g < 16; g++) begin
      logic [5:0] b;
      b = {4'(g), 2'(g)};
      for (int n = 0; n < 4; n++) begin
        logic [5:0] a;
        a = baddr(b, n, 1'b0);
        model[a] = pat(a, 0);
        cmd(n == 0 ? 1'b0 : 1'b1, 0, 0, 0, 0, 4'b1010, b, model[a]);
        tick();
        chk("R8 write no drive", {31'd0, rdrive}, 32'd0);
      end
    end
    deselect2();

    // Flow-through read sweep (R2, R4, R6)
    for (int a = 0; a < 64; a++) begin
      cmd(0, 0, 1, 1, 1, 4'h0, 6'(a), 0); tick();
      chk("R2 flow drive", {31'd0, rdrive}, 32'd1);
      chk("R6/R4 flow data", rdata, model[a]);
    end
    deselect2();

    // Hold with adv_n high (R4)
    cmd(0, 0, 1, 1, 1, 4'hF, 6'd13, 0); tick();
    cmd(1, 0, 1, 1, 1, 4'hF, 6'd0, 0); tick();
    chk("R4 hold", rdata, model[13]);
    cmd(1, 0, 0, 1, 1, 4'hF, 6'd0, 0); tick();
    chk("R4 advance", rdata, model[14]);
    deselect2();

    // Byte writes then read-after-write (R7, R8)
    for (int p = 0; p < 16; p++) begin
      int a;
      logic [31:0] d;
      a = p * 3 + 1;
      d = pat(a, 7);
      for (int l = 0; l < 4; l++)
        if (!p[l]) model[a][l*8 +: 8] = d[l*8 +: 8];
      cmd(0, 0, 1, 1, 0, 4'(p), 6'(a), d); tick();
      chk("R8 byte write no drive", {31'd0, rdrive}, 32'd0);
      cmd(0, 0, 1, 1, 1, 4'(p), 6'(a), ~d); tick();
      chk("R7 byte lanes", rdata, model[a]);
    end
    deselect2();

    // Pipelined bursts in both orders (R3, R4, R5, R9)
    pipe_mode = 1'b1;
    for (int o = 0; o < 2; o++) begin
      burst_ilv = o[0];
      for (int b = 0; b < 64; b += 5) begin
        for (int n = 0; n < 4; n++) begin
          cmd(n == 0 ? 1'b0 : 1'b1, 0, 0, 1, 1, 4'hF, 6'(b), 0); tick();
          if (n == 0) chk("R3 no early data", {31'd0, rdrive}, 32'd0);
          else chk(o == 0 ? "R4 linear beat" : "R5 interleave beat", rdata,
                   model[baddr(6'(b), n - 1, o[0])]);
        end
        cmd(0, 1, 1, 1, 1, 4'hF, 0, 0); tick();
        chk("R9 last word kept", rdata, model[baddr(6'(b), 3, o[0])]);
        cmd(1, 1, 0, 1, 1, 4'hF, 0, 0); tick();
        chk("R9 drive off", {31'd0, rdrive}, 32'd0);
      end
    end
    burst_ilv = 1'b0;
    pipe_mode = 1'b0;
    deselect2();

    // Asynchronous output enable (R10)
    cmd(0, 0, 1, 1, 1, 4'hF, 6'd40, 0); tick();
    #2 oe_n = 1'b1;
    #1 chk("R10 oe off drive", {31'd0, rdrive}, 32'd0);
    chk("R10 oe off data", rdata, 32'd0);
    #1 oe_n = 1'b0;
    #1 chk("R10 oe restore", rdata, model[40]);
    deselect2();

    // Sleep (R11)
    pipe_mode = 1'b1;
    cmd(0, 0, 1, 1, 1, 4'hF, 6'd22, 0); tick();
    cmd(1, 0, 1, 1, 1, 4'hF, 6'd0, 0); tick();
    chk("R11 pre-sleep data", rdata, model[22]);
    #2 sleep = 1'b1;
    #1 chk("R11 sleep drive", {31'd0, rdrive}, 32'd0);
    cmd(0, 0, 1, 0, 0, 4'h0, 6'd22, 32'hDEADBEEF); tick();
    tick();
    sleep = 1'b0;
    cmd(1, 0, 0, 1, 1, 4'hF, 6'd0, 0); tick();
    chk("R11 flushed", {31'd0, rdrive}, 32'd0);
    tick();
    chk("R11 no resume", {31'd0, rdrive}, 32'd0);
    pipe_mode = 1'b0;
    deselect2();
    cmd(0, 0, 1, 1, 1, 4'hF, 6'd22, 0); tick();
    chk("R11 data kept", rdata, model[22]);
    deselect2();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule